// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit with Unaligned Merge

This block is the memory-access stage of a little-endian 32-bit load/store core. For each operation it adds a base register value to a sign-extended 16-bit displacement. It then runs one access on a simple synchronous memory port and returns the value to be written back to the register file.

Byte, halfword and word loads return their result sign-extended or zero-extended. Byte, halfword and word stores drive only the byte lanes they address. Four partial-word operations move bytes between a register and an aligned memory word in a left-hand or right-hand arrangement, selected by the low two address bits. Two of them are loads that merge memory bytes into the register. The other two are stores that read the word, merge register bytes into it and write the whole word back.

An operation is started with a one-cycle `start` while the unit is idle. Completion is marked by a one-cycle `done`, together with `wbEn` when there is a register to update. The memory returns read data in the cycle after `memRd`.

Top module: `lane_lsu`

## Requirements
- R1: The effective address is `baseVal` plus `offset` sign-extended to 32 bits. Whenever `memRd` or `memWe` is high, `memAddr` is that address with bits [1:0] forced to zero.
- R2: Op codes: 0 byte load signed, 3 byte load unsigned, 1 halfword load signed, 4 halfword load unsigned. Byte k of the word (bits 8k+7..8k) is selected by address bits [1:0]. The low half is selected when address bit 1 is 0 and the high half when it is 1; bit 0 is ignored. Signed loads replicate the top bit of the selected data; unsigned loads fill with zeros.
- R3: Op 2 (word load) returns the full memory word.
- R4: Op 8 (byte store) sets only `memBe` bit k and puts the register's low byte on all four lanes. Op 9 (halfword store) enables lanes 0-1 or 2-3 according to address bit 1 and puts the low halfword on both halves. Op 10 (word store) enables all lanes with the register value.
- R5: Op 5 (left load), with k = address bits [1:0]: result bytes k+1 down to... namely the top k+1 bytes of the result are memory bytes 0..k. The remaining low bytes keep the `regVal` bytes. With k = 3 the result is the whole memory word.
- R6: Op 6 (right load): the low 4-k result bytes are memory bytes k..3. The remaining top bytes keep `regVal`. With k = 0 the result is the whole memory word.
- R7: Op 11 (left store): the unit reads the aligned word, then writes it with all four enables. Memory bytes 0..k are replaced by the top k+1 register bytes, and the other bytes are left as they were.
- R8: Op 12 (right store): the unit reads the aligned word, then writes it with all four enables. Memory bytes k..3 are replaced by register bytes 0..3-k, and the other bytes are left as they were.
- R9: A load with `dstIdx` = 0 still performs its memory read, but `wbEn` stays low.
- R10: Counting from the clock edge that accepts `start`, `done` rises after these numbers of cycles: loads 3, byte/halfword/word stores 2, partial-word stores 4, other op codes 1. Other op codes make no memory access. `done` lasts one cycle and `wbEn` is high only together with `done`.
- R11: After reset `done`, `wbEn`, `memRd`, `memWe` and `busy` are low.
- R12: `memRd` and `memWe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| opSel | input | 4 | Operation code |
| baseVal | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| regVal | input | 32 | Store data / register value for merging loads |
| dstIdx | input | 5 | Destination register index |
| memAddr | output | 32 | Word-aligned memory address |
| memRd | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memBe | output | 4 | Byte enables for the write |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Read data, valid the cycle after memRd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wbEn | output | 1 | Writeback valid |
| wbData | output | 32 | Writeback value |

## Verification
If the captured address offset or op code were wrong, the merged value would pick the wrong byte mix. This appears on `wbData` in the `done` cycle of the same operation for loads. For partial-word stores it appears in the memory word one cycle before `done`. A control state that takes a wrong turn shows up as a `done` pulse at a latency different from R10, or as a stray or missing read strobe. Each operation is therefore scored on its writeback, the resulting memory word, the number of reads and its exact latency. Every offset of the four merges, every byte lane and both extension modes are covered.

// File: rtl/lane_lsu_pkg.sv
package lane_lsu_pkg;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 16;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int OP_W    = 4;
  localparam int REG_W   = 5;

  localparam logic [OP_W-1:0] OP_LB  = 4'd0;
  localparam logic [OP_W-1:0] OP_LH  = 4'd1;
  localparam logic [OP_W-1:0] OP_LW  = 4'd2;
  localparam logic [OP_W-1:0] OP_LBU = 4'd3;
  localparam logic [OP_W-1:0] OP_LHU = 4'd4;
  localparam logic [OP_W-1:0] OP_LWL = 4'd5;
  localparam logic [OP_W-1:0] OP_LWR = 4'd6;
  localparam logic [OP_W-1:0] OP_SB  = 4'd8;
  localparam logic [OP_W-1:0] OP_SH  = 4'd9;
  localparam logic [OP_W-1:0] OP_SW  = 4'd10;
  localparam logic [OP_W-1:0] OP_SWL = 4'd11;
  localparam logic [OP_W-1:0] OP_SWR = 4'd12;

  typedef enum logic [1:0] {
    CLS_NONE, CLS_LOAD, CLS_STORE, CLS_MERGE_ST
  } opClass_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capIn;   // latch operands
    logic rd;      // drive memory read
    logic capRes;  // latch merged result
    logic wr;      // drive memory write
    logic fin;     // completion cycle
  } strobe_t;

  function automatic opClass_e classify(input logic [OP_W-1:0] op);
    case (op)
      OP_LB, OP_LH, OP_LW, OP_LBU, OP_LHU, OP_LWL, OP_LWR: classify = CLS_LOAD;
      OP_SB, OP_SH, OP_SW:                                 classify = CLS_STORE;
      OP_SWL, OP_SWR:                                      classify = CLS_MERGE_ST;
      default:                                             classify = CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lane_lsu_ctrl.sv
module lane_lsu_ctrl
  import lane_lsu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opSel,
  output strobe_t         stb,
  output logic            busy
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_FIN} state_e;

  state_e   state, nextState;
  logic     needWr, nextNeedWr;
  opClass_e cls;

  assign cls = classify(opSel);

  always_comb begin
    nextState  = state;
    nextNeedWr = needWr;
    case (state)
      S_IDLE: if (start) begin
        nextNeedWr = (cls == CLS_MERGE_ST);
        case (cls)
          CLS_LOAD, CLS_MERGE_ST: nextState = S_RD;
          CLS_STORE:              nextState = S_WR;
          default:                nextState = S_FIN;
        endcase
      end
      S_RD:  nextState = S_CAP;
      S_CAP: nextState = needWr ? S_WR : S_FIN;
      S_WR:  nextState = S_FIN;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      needWr <= 1'b0;
    end else begin
      state  <= nextState;
      needWr <= nextNeedWr;
    end
  end

  always_comb begin
    stb.capIn  = (state == S_IDLE) && start;
    stb.rd     = (state == S_RD);
    stb.capRes = (state == S_CAP);
    stb.wr     = (state == S_WR);
    stb.fin    = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/lane_lsu_dp.sv
module lane_lsu_dp
  import lane_lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] regVal,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData
);
  localparam logic [DATA_W-1:0] LOW3 = {8'h00, {(DATA_W-8){1'b1}}};
  localparam logic [DATA_W-1:0] HIGH3 = {{(DATA_W-8){1'b1}}, 8'h00};

  logic [DATA_W-1:0] eaR, regR, resR, merged, eaNext;
  logic [OP_W-1:0]   opR;
  logic [REG_W-1:0]  dstR;
  logic [LANE_W-1:0] lane;
  logic [4:0]        sh, shInv;
  logic [7:0]        pickB;
  logic [15:0]       pickH;

  assign eaNext = baseVal + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaR  <= '0;
      regR <= '0;
      opR  <= '0;
      dstR <= '0;
      resR <= '0;
    end else begin
      if (stb.capIn) begin
        eaR  <= eaNext;
        regR <= regVal;
        opR  <= opSel;
        dstR <= dstIdx;
      end
      if (stb.capRes) resR <= merged;
    end
  end

  assign lane  = eaR[LANE_W-1:0];
  assign sh    = {lane, 3'b000};
  assign shInv = 5'd24 - sh;
  assign pickB = memRdata[sh +: 8];
  assign pickH = eaR[1] ? memRdata[31:16] : memRdata[15:0];

  always_comb begin
    case (opR)
      OP_LB:   merged = {{24{pickB[7]}}, pickB};
      OP_LBU:  merged = {24'h0, pickB};
      OP_LH:   merged = {{16{pickH[15]}}, pickH};
      OP_LHU:  merged = {16'h0, pickH};
      OP_LW:   merged = memRdata;
      OP_LWL:  merged = (memRdata << shInv) | (regR & (LOW3 >> sh));
      OP_LWR:  merged = (memRdata >> sh) | (regR & (HIGH3 << shInv));
      OP_SWL:  merged = (regR >> shInv) | (memRdata & (HIGH3 << sh));
      OP_SWR:  merged = (regR << sh) | (memRdata & (LOW3 >> shInv));
      default: merged = '0;
    endcase
  end

  assign memAddr = {eaR[DATA_W-1:LANE_W], {LANE_W{1'b0}}};

  always_comb begin
    case (opR)
      OP_SB: begin
        memBe    = LANES'(1) << lane;
        memWdata = {LANES{regR[7:0]}};
      end
      OP_SH: begin
        memBe    = eaR[1] ? 4'b1100 : 4'b0011;
        memWdata = {2{regR[15:0]}};
      end
      OP_SWL, OP_SWR: begin
        memBe    = '1;
        memWdata = resR;
      end
      default: begin
        memBe    = '1;
        memWdata = regR;
      end
    endcase
  end

  assign wbEn   = stb.fin && (classify(opR) == CLS_LOAD) && (dstR != '0);
  assign wbData = resR;
endmodule

// File: rtl/lane_lsu.sv
module lane_lsu
  import lane_lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  opSel,
  input  logic [31:0] baseVal,
  input  logic [15:0] offset,
  input  logic [31:0] regVal,
  input  logic [4:0]  dstIdx,
  output logic [31:0] memAddr,
  output logic        memRd,
  output logic        memWe,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        busy,
  output logic        done,
  output logic        wbEn,
  output logic [31:0] wbData
);
  strobe_t stb;

  lane_lsu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .stb(stb), .busy(busy)
  );

  lane_lsu_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .opSel(opSel),
    .baseVal(baseVal), .offset(offset), .regVal(regVal), .dstIdx(dstIdx),
    .memRdata(memRdata), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .wbEn(wbEn), .wbData(wbData)
  );

  assign memRd = stb.rd;
  assign memWe = stb.wr;
  assign done  = stb.fin;
endmodule

// File: rtl/lane_lsu_chk.sv
module lane_lsu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memRd,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [3:0]  memBe,
  input logic        done,
  input logic        wbEn
);
  // R12
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWe));

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWe) |-> (memAddr[1:0] == 2'b00));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);

  // R4
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memBe != 4'b0000));

  // R10
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWe) |=> !memRd);
endmodule

bind lane_lsu lane_lsu_chk uChk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWe(memWe),
  .memAddr(memAddr), .memBe(memBe), .done(done), .wbEn(wbEn)
);

// File: tb/lane_lsu_test.sv
module lane_lsu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] baseVal = '0;
  logic [15:0] offset = '0;
  logic [31:0] regVal = '0;
  logic [4:0]  dstIdx = '0;
  logic [31:0] memAddr, memWdata, memRdata, wbData;
  logic        memRd, memWe, busy, done, wbEn;
  logic [3:0]  memBe;

  lane_lsu uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model
  logic [31:0] mem [16];
  logic [3:0]  lastBe;
  int          rdCount = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRd) begin
      memRdata <= mem[memAddr[5:2]];
      rdCount  <= rdCount + 1;
    end
    if (memWe) begin
      for (int i = 0; i < 4; i++)
        if (memBe[i]) mem[memAddr[5:2]][8*i +: 8] <= memWdata[8*i +: 8];
      lastBe <= memBe;
    end
  end

  typedef struct {
    string       req;
    logic        expWb;
    logic [31:0] wb;
    logic [3:0]  idx;
    logic [31:0] word;
    int          rdTotal;
    int          lat;
    int          startCyc;
    logic        chkBe;
    logic [3:0]  be;
  } item_t;

  item_t q[$];
  int    tests = 0, fails = 0;
  int    expRd = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(wbEn == it.expWb, it.req, "wbEn", {31'd0, wbEn}, {31'd0, it.expWb});
        if (it.expWb) chk(wbData == it.wb, it.req, "wbData", wbData, it.wb);
        chk(mem[it.idx] == it.word, it.req, "memory word", mem[it.idx], it.word);
        chk(rdCount == it.rdTotal, it.req, "read count", rdCount, it.rdTotal);
        chk(cyc - it.startCyc == it.lat, "R10", "latency",
            cyc - it.startCyc, it.lat);
        if (it.chkBe) chk(lastBe == it.be, it.req, "byte enables",
                          {28'd0, lastBe}, {28'd0, it.be});
      end
    end
  end

  // driver
  task automatic doOp(input logic [3:0] op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] rv,
                      input logic [4:0] dst, input string req);
    item_t       it;
    logic [31:0] ea, w, r, nw;
    int          k;
    ea = base + {{16{off[15]}}, off};
    k  = int'(ea[1:0]);
    w  = mem[ea[5:2]];
    r  = 32'h0;
    nw = w;
    it.chkBe = 1'b0;
    it.be    = 4'hF;
    it.lat   = 1;
    case (op)
      4'd0: r = {{24{w[8*k+7]}}, w[8*k +: 8]};
      4'd3: r = {24'h0, w[8*k +: 8]};
      4'd1: r = ea[1] ? {{16{w[31]}}, w[31:16]} : {{16{w[15]}}, w[15:0]};
      4'd4: r = ea[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
      4'd2: r = w;
      4'd5: for (int i = 0; i < 4; i++)
              r[8*i +: 8] = (i >= 3 - k) ? w[8*(i-3+k) +: 8] : rv[8*i +: 8];
      4'd6: for (int i = 0; i < 4; i++)
              r[8*i +: 8] = (i <= 3 - k) ? w[8*(i+k) +: 8] : rv[8*i +: 8];
      4'd8: begin nw[8*k +: 8] = rv[7:0]; it.be = 4'(1 << k); end
      4'd9: begin
        if (ea[1]) begin nw[31:16] = rv[15:0]; it.be = 4'b1100; end
        else begin nw[15:0] = rv[15:0]; it.be = 4'b0011; end
      end
      4'd10: nw = rv;
      4'd11: for (int j = 0; j < 4; j++)
               if (j <= k) nw[8*j +: 8] = rv[8*(j+3-k) +: 8];
      4'd12: for (int j = 0; j < 4; j++)
               if (j >= k) nw[8*j +: 8] = rv[8*(j-k) +: 8];
      default: ;
    endcase
    if (op <= 4'd6) begin it.lat = 3; expRd++; end
    else if (op >= 4'd8 && op <= 4'd10) begin it.lat = 2; it.chkBe = 1'b1; end
    else if (op == 4'd11 || op == 4'd12) begin it.lat = 4; expRd++; it.chkBe = 1'b1; end
    it.req     = req;
    it.expWb   = (op <= 4'd6) && (dst != 5'd0);
    it.wb      = r;
    it.idx     = ea[5:2];
    it.word    = nw;
    it.rdTotal = expRd;
    it.startCyc = cyc;
    q.push_back(it);
    opSel = op; baseVal = base; offset = off; regVal = rv; dstIdx = dst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h10203040 + 32'h01010101 * i;
    mem[1] = 32'hF27F8001;
    mem[2] = 32'h7FFF8000;
    mem[3] = 32'h44332211;
    memRdata = '0;
    lastBe = '0;
    repeat (3) @(negedge clk);
    // R11
    chk(!done && !wbEn && !memRd && !memWe && !busy, "R11", "reset outputs",
        {27'd0, done, wbEn, memRd, memWe, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 byte loads, all lanes, both extensions; R1 via negative offsets
    for (int l = 0; l < 4; l++) begin
      doOp(4'd0, 32'h14, 16'hFFF0 + 16'(l), 32'h0, 5'd3, "R2");
      doOp(4'd3, 32'h4 + 32'(l), 16'h0, 32'h0, 5'd3, "R2");
    end
    // R2 halfword loads
    for (int h = 0; h < 2; h++) begin
      doOp(4'd1, 32'h8, 16'(2*h), 32'h0, 5'd4, "R2");
      doOp(4'd4, 32'h9, 16'(2*h), 32'h0, 5'd4, "R2");
    end
    // R3 and R1 with a large base
    doOp(4'd2, 32'h1000_000C, 16'h0, 32'h0, 5'd1, "R3");
    doOp(4'd2, 32'h20, 16'hFFE4, 32'h0, 5'd1, "R1");
    // R5 / R6 all offsets
    for (int k = 0; k < 4; k++) begin
      doOp(4'd5, 32'hC + 32'(k), 16'h0, 32'hAABBCCDD, 5'd7, "R5");
      doOp(4'd6, 32'hC + 32'(k), 16'h0, 32'hAABBCCDD, 5'd7, "R6");
    end
    // R7 / R8 all offsets
    for (int k = 0; k < 4; k++) begin
      doOp(4'd11, 32'h10 + 32'(k), 16'h0, 32'hA1B2C3D4, 5'd0, "R7");
      doOp(4'd12, 32'h18 + 32'(k), 16'h0, 32'h5E6F7A8B, 5'd0, "R8");
    end
    // R4 stores on every lane
    for (int l = 0; l < 4; l++) doOp(4'd8, 32'h20 + 32'(l), 16'h0, 32'h123456EE, 5'd0, "R4");
    for (int h = 0; h < 2; h++) doOp(4'd9, 32'h24 + 32'(2*h), 16'h0, 32'h1234BEEF, 5'd0, "R4");
    doOp(4'd10, 32'h2C, 16'hFFFC, 32'hCAFEF00D, 5'd0, "R4");
    // R9 load to register zero
    doOp(4'd2, 32'h4, 16'h0, 32'h0, 5'd0, "R9");
    doOp(4'd5, 32'hD, 16'h0, 32'h0, 5'd0, "R9");
    // R10 undefined code: no access, one-cycle latency
    doOp(4'd7, 32'h4, 16'h0, 32'hFFFFFFFF, 5'd2, "R10");
    doOp(4'd15, 32'h8, 16'h0, 32'hFFFFFFFF, 5'd2, "R10");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "pending items", q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule